// File: doc/BRIEF.md
# Two-Wire Bus State Monitor

This block watches the clock and data lines of a two-wire serial bus and keeps a two-bit view of who holds the bus. It recognises the framing conditions on the lines, START and STOP, and flags a START that arrives inside an open frame as a repeated START. Each condition is reported as a one-cycle pulse. A host controller reads the state before it tries to take the bus, and software reads the same value.

The state moves from unknown or busy to idle in three ways: a STOP is seen, the lines stay quiet for an inactivity window, or software strobes a force-to-idle. The inactivity timer runs in normal operation as well, not only after reset, and it behaves the same for plain I2C and SMBus traffic. Its default window is 200 µs. The number of clock cycles for that window is derived from the clock-frequency parameter. A run-time limit input can replace the default with a shorter or longer window. The line inputs must already be synchronised to `clk`. Arbitration and data movement belong to the host engine. The host engine tells the monitor, through `own_i`, whether a START is its own.

Top module: `twbus_state_monitor`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `bus_state_o` is 0 (unknown) and all detect pulses are low. With the timer disabled and no line activity, the state stays unknown and is never assumed idle.
- R2: A START means `sda_i` goes from 1 to 0 between two clock samples while `scl_i` is 1 in both samples. It raises `start_o` for exactly one cycle, in the cycle that follows the sampling edge where the change is first seen. No other line transition raises `start_o`.
- R3: A STOP means `sda_i` goes from 0 to 1 while `scl_i` is 1 in both samples. It raises `stop_o` for exactly one cycle, with the same latency as R2. No other transition raises `stop_o`.
- R4: `rstart_o` pulses together with `start_o` only when a START arrives after an earlier START with no STOP, force-idle or timeout expiry in between. The first START after a STOP does not raise it.
- R5: If `own_i` is 0 in the cycle where `start_o` is high, the state becomes 3 (busy) one cycle later.
- R6: If `own_i` is 1 in the cycle where `start_o` is high, the state becomes 2 (owner) one cycle later. This holds for a repeated START too.
- R7: The cycle after `stop_o` is high, the state is 1 (idle), whatever the state was before.
- R8: Let `tmo_en_i` be 1 and let `tmo_limit_i` = L, with L ≥ 1. Suppose the last change on either line is sampled at edge k. A busy or unknown state becomes idle at edge k+L+2, provided no START, STOP or force-idle intervenes. Any edge on `scl_i` or `sda_i` restarts the window.
- R9: A `tmo_limit_i` of 0 selects the built-in window: CLK_HZ·TMO_US/10^6 cycles, at least 1.
- R10: The timeout never changes the owner or idle state. No timeout occurs while `tmo_en_i` is 0.
- R11: If `force_idle_i` is 1 at an edge, the state is idle right after that edge. The timer is cleared and the open frame is closed, so the next START is not flagged as repeated.
- R12: Priorities within one cycle: force-idle beats a START, so the state goes idle. A START beats a timeout expiry, so the state goes busy or owner.
- R13: Toggling `sda_i` while `scl_i` is low produces no pulse and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised clock line of the bus |
| sda_i | input | 1 | Synchronised data line of the bus |
| own_i | input | 1 | Local host engine is the one issuing the current START |
| force_idle_i | input | 1 | Software strobe that forces the idle state |
| tmo_en_i | input | 1 | Enables the inactivity timeout |
| tmo_limit_i | input | CNT_W | Timeout length in cycles; 0 selects the 200 µs default |
| bus_state_o | output | 2 | 0 unknown, 1 idle, 2 owner, 3 busy |
| start_o | output | 1 | One-cycle START detect pulse |
| rstart_o | output | 1 | One-cycle repeated-START pulse, coincident with start_o |
| stop_o | output | 1 | One-cycle STOP detect pulse |

## Verification
Two pairs of events can land in one cycle, and each pair is set up on purpose by timing the stimulus.

The first pair is force-idle and START. The bench raises `force_idle_i` in exactly the cycle where `start_o` is high. The case is judged by the state being idle the next cycle rather than busy.

The second pair is timeout expiry and START. The bench first makes the bus busy. It then lets the lines sit quiet for L+1 cycles after the last edge, and drops SDA with SCL high so that the START is sampled on the edge where the expiry fires. The state must read busy in the following cycle. An idle reading there would show that the expiry won.

// File: rtl/twbm_pkg.sv
package twbm_pkg;

  typedef enum logic [1:0] {
    BUS_UNKNOWN = 2'd0,
    BUS_IDLE    = 2'd1,
    BUS_OWNER   = 2'd2,
    BUS_BUSY    = 2'd3
  } bus_state_e;

  // Number of clock cycles in the inactivity window, never below one.
  function automatic int unsigned twbm_tmo_cycles(input int unsigned clk_hz,
                                                  input int unsigned tmo_us);
    longint unsigned cyc;
    cyc = (longint'(clk_hz) * longint'(tmo_us)) / 64'd1_000_000;
    if (cyc == 0) cyc = 1;
    return cyc[31:0];
  endfunction

endpackage

// File: rtl/twbm_cond_det.sv
// Samples both lines and reports framing conditions and line activity.
module twbm_cond_det #(
  parameter int unsigned LINES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic frame_clr_i,
  output logic start_o,
  output logic rstart_o,
  output logic stop_o,
  output logic activity_o
);
  localparam int unsigned IDX_SCL = 0;
  localparam int unsigned IDX_SDA = 1;

  logic [LINES-1:0] line_now;
  logic [LINES-1:0] line_q;
  logic [LINES-1:0] line_edge;
  logic             primed_q;
  logic             framed_q;
  logic             start_c;
  logic             stop_c;

  assign line_now[IDX_SCL] = scl_i;
  assign line_now[IDX_SDA] = sda_i;

  // One sample register and one edge flag per line.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) line_q[g] <= 1'b1;
      else     line_q[g] <= line_now[g];
    end
    assign line_edge[g] = primed_q & (line_q[g] ^ line_now[g]);
  end

  always_comb begin
    start_c = primed_q & line_q[IDX_SCL] & line_now[IDX_SCL]
            &  line_q[IDX_SDA] & ~line_now[IDX_SDA];
    stop_c  = primed_q & line_q[IDX_SCL] & line_now[IDX_SCL]
            & ~line_q[IDX_SDA] &  line_now[IDX_SDA];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q   <= 1'b0;
      framed_q   <= 1'b0;
      start_o    <= 1'b0;
      rstart_o   <= 1'b0;
      stop_o     <= 1'b0;
      activity_o <= 1'b0;
    end else begin
      primed_q   <= 1'b1;
      start_o    <= start_c;
      rstart_o   <= start_c & framed_q;
      stop_o     <= stop_c;
      activity_o <= |line_edge;
      if (start_c)                      framed_q <= 1'b1;
      else if (stop_c || frame_clr_i)   framed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/twbm_idle_timer.sv
// Counts quiet cycles; one-cycle expire pulse when the window is reached.
module twbm_idle_timer #(
  parameter int unsigned          CNT_W     = 8,
  parameter logic [CNT_W-1:0]     DEF_LIMIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             activity_i,
  input  logic             clear_i,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_eff;
  logic [CNT_W-1:0] cnt_inc;

  assign lim_eff = (limit_i == '0) ? DEF_LIMIT : limit_i;
  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (!enable_i || clear_i || activity_i) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (cnt_q != lim_eff) begin
      cnt_q    <= cnt_inc;
      expire_o <= (cnt_inc == lim_eff);
    end else begin
      expire_o <= 1'b0;
    end
  end

endmodule

// File: rtl/twbm_state_fsm.sv
// Holds the two-bit bus state; event priority force > start > stop > expiry.
module twbm_state_fsm
  import twbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       expire_i,
  input  logic       force_i,
  input  logic       own_i,
  output bus_state_e state_o
);
  logic held_by_other;

  assign held_by_other = (state_o == BUS_BUSY) || (state_o == BUS_UNKNOWN);

  always_ff @(posedge clk) begin
    if (rst)                          state_o <= BUS_UNKNOWN;
    else if (force_i)                 state_o <= BUS_IDLE;
    else if (start_i)                 state_o <= own_i ? BUS_OWNER : BUS_BUSY;
    else if (stop_i)                  state_o <= BUS_IDLE;
    else if (expire_i && held_by_other) state_o <= BUS_IDLE;
  end

endmodule

// File: rtl/twbus_state_monitor.sv
module twbus_state_monitor
  import twbm_pkg::*;
#(
  parameter int unsigned  CLK_HZ  = 200_000_000,
  parameter int unsigned  TMO_US  = 200,
  localparam int unsigned TMO_CYC = twbm_tmo_cycles(CLK_HZ, TMO_US),
  localparam int unsigned CNT_W   = $clog2(TMO_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             own_i,
  input  logic             force_idle_i,
  input  logic             tmo_en_i,
  input  logic [CNT_W-1:0] tmo_limit_i,
  output logic [1:0]       bus_state_o,
  output logic             start_o,
  output logic             rstart_o,
  output logic             stop_o
);
  logic       act_w;
  logic       expire_w;
  logic       frame_clr_w;
  bus_state_e state_w;

  // An expiry that loses to a coincident START must not close the new frame.
  assign frame_clr_w = force_idle_i | (expire_w & ~start_o);

  twbm_cond_det #(.LINES(2)) u_det (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .frame_clr_i(frame_clr_w),
    .start_o    (start_o),
    .rstart_o   (rstart_o),
    .stop_o     (stop_o),
    .activity_o (act_w)
  );

  twbm_idle_timer #(
    .CNT_W    (CNT_W),
    .DEF_LIMIT(CNT_W'(TMO_CYC))
  ) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .activity_i(act_w),
    .clear_i   (force_idle_i),
    .enable_i  (tmo_en_i),
    .limit_i   (tmo_limit_i),
    .expire_o  (expire_w)
  );

  twbm_state_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_o),
    .stop_i  (stop_o),
    .expire_i(expire_w),
    .force_i (force_idle_i),
    .own_i   (own_i),
    .state_o (state_w)
  );

  assign bus_state_o = state_w;

endmodule

// File: rtl/twbm_checker.sv
module twbm_checker (
  input logic       clk_i,
  input logic       rst_i,
  input logic [1:0] state_i,
  input logic       start_i,
  input logic       rstart_i,
  input logic       stop_i,
  input logic       own_i,
  input logic       force_i,
  input logic       expire_i
);
  assert_reset_unknown_R1: assert property (@(posedge clk_i)
    rst_i |=> (state_i == 2'd0 && !start_i && !stop_i && !rstart_i));

  assert_start_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    start_i |=> !start_i);

  assert_stop_single_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    stop_i |=> !stop_i);

  assert_no_start_and_stop_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !(start_i && stop_i));

  assert_rstart_with_start_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    rstart_i |-> start_i);

  assert_start_busy_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !force_i && !own_i) |=> state_i == 2'd3);

  assert_start_owner_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !force_i && own_i) |=> state_i == 2'd2);

  assert_stop_idle_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (stop_i && !force_i) |=> state_i == 2'd1);

  assert_expire_idle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (expire_i && !start_i && !force_i && (state_i == 2'd3 || state_i == 2'd0))
      |=> state_i == 2'd1);

  assert_owner_kept_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_i == 2'd2 && !start_i && !stop_i && !force_i) |=> state_i == 2'd2);

  assert_force_idle_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    force_i |=> state_i == 2'd1);

  assert_quiet_stable_R13: assert property (@(posedge clk_i) disable iff (rst_i)
    (!start_i && !stop_i && !force_i && !expire_i) |=> $stable(state_i));

endmodule

bind twbus_state_monitor twbm_checker u_chk (
  .clk_i   (clk),
  .rst_i   (rst),
  .state_i (bus_state_o),
  .start_i (start_o),
  .rstart_i(rstart_o),
  .stop_i  (stop_o),
  .own_i   (own_i),
  .force_i (force_idle_i),
  .expire_i(expire_w)
);

// File: tb/tb_twbus_state_monitor.sv
`timescale 1ns/1ps
module tb_twbus_state_monitor;
  localparam int unsigned CLK_HZ  = 1_000_000;
  localparam int unsigned TMO_US  = 200;
  localparam int unsigned DEF_CYC = CLK_HZ / 1_000_000 * TMO_US;  // 200
  localparam int unsigned LW      = $clog2(DEF_CYC + 1);

  localparam logic [31:0] ST_UNK = 0, ST_IDLE = 1, ST_OWN = 2, ST_BUSY = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scl = 1'b1;
  logic          sda = 1'b1;
  logic          own = 1'b0;
  logic          frc = 1'b0;
  logic          ten = 1'b0;
  logic [LW-1:0] lim = '0;
  logic [1:0]    st;
  logic          s_d, r_d, p_d;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  twbus_state_monitor #(.CLK_HZ(CLK_HZ), .TMO_US(TMO_US)) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .own_i(own),
    .force_idle_i(frc), .tmo_en_i(ten), .tmo_limit_i(lim),
    .bus_state_o(st), .start_o(s_d), .rstart_o(r_d), .stop_o(p_d)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Ends with a STOP, so the state is idle and the frame is closed.
  task automatic release_bus();
    scl = 1'b1; sda = 1'b0; tick(2);
    sda = 1'b1; tick(3);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    tick(3);
    rst = 1'b0;
    chk("R1 state after reset", 32'(st), ST_UNK);
    chk("R1 pulses after reset", {29'd0, s_d, r_d, p_d}, 0);
    tick(6);
    chk("R1 stays unknown", 32'(st), ST_UNK);

    // R2/R3/R13: sweep every (prev, cur) pair of {scl,sda}
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] es, ep;
        scl = p[1]; sda = p[0]; tick(3);
        scl = c[1]; sda = c[0]; tick();
        es = (p == 3 && c == 2) ? 1 : 0;
        ep = (p == 2 && c == 3) ? 1 : 0;
        chk("R2 start detect sweep", 32'(s_d), es);
        chk("R3 stop detect sweep", 32'(p_d), ep);
        tick();
        chk("R2 start pulse one cycle", {30'd0, s_d, p_d}, 0);
      end
    end

    // R5/R4/R6/R7
    ten = 1'b0;
    release_bus();
    chk("R7 idle after stop", 32'(st), ST_IDLE);
    own = 1'b0; sda = 1'b0; tick();
    chk("R2 start pulse", 32'(s_d), 1);
    chk("R4 first start not repeated", 32'(r_d), 0);
    tick();
    chk("R5 busy after foreign start", 32'(st), ST_BUSY);
    scl = 1'b0; tick(); sda = 1'b1; tick(); scl = 1'b1; tick();
    own = 1'b1; sda = 1'b0; tick();
    chk("R4 repeated start start_o", 32'(s_d), 1);
    chk("R4 repeated start flag", 32'(r_d), 1);
    tick();
    chk("R6 owner after own repeated start", 32'(st), ST_OWN);
    scl = 1'b0; tick(); scl = 1'b1; tick();
    sda = 1'b1; tick();
    chk("R3 stop pulse", 32'(p_d), 1);
    tick();
    chk("R7 idle after stop from owner", 32'(st), ST_IDLE);
    sda = 1'b0; tick(2);
    chk("R6 owner from idle", 32'(st), ST_OWN);
    ten = 1'b1; lim = LW'(5); tick(20);
    chk("R10 owner ignores timeout", 32'(st), ST_OWN);
    sda = 1'b1; tick(2);
    chk("R7 idle after stop", 32'(st), ST_IDLE);
    own = 1'b0;

    // R13: SDA toggling under low SCL
    scl = 1'b0; tick();
    for (int i = 0; i < 6; i++) begin
      sda = ~sda; tick();
      chk("R13 no pulse with scl low", {30'd0, s_d, p_d}, 0);
    end
    chk("R13 idle kept", 32'(st), ST_IDLE);
    sda = 1'b1; tick(); scl = 1'b1; tick(2);
    chk("R10 idle unaffected by timeout", 32'(st), ST_IDLE);

    // R8: timeout window sweep
    ten = 1'b1;
    for (int L = 1; L <= 10; L++) begin
      lim = LW'(L);
      release_bus();
      sda = 1'b0; tick(2);
      chk("R8 busy before window", 32'(st), ST_BUSY);
      tick(L);
      chk("R8 busy at k+L+1", 32'(st), ST_BUSY);
      tick();
      chk("R8 idle at k+L+2", 32'(st), ST_IDLE);
    end
    lim = LW'(8);
    release_bus();
    sda = 1'b0; tick(5);
    chk("R8 busy before restart", 32'(st), ST_BUSY);
    scl = 1'b0; tick(10);
    chk("R8 edge restarts window", 32'(st), ST_BUSY);
    tick();
    chk("R8 idle after restarted window", 32'(st), ST_IDLE);

    // R10: disabled timer; R9: default window
    ten = 1'b0;
    release_bus();
    sda = 1'b0; tick(40);
    chk("R10 no timeout when disabled", 32'(st), ST_BUSY);
    ten = 1'b1; lim = '0;
    release_bus();
    sda = 1'b0; tick(DEF_CYC + 2);
    chk("R9 busy before default window", 32'(st), ST_BUSY);
    tick();
    chk("R9 idle at default window", 32'(st), ST_IDLE);

    // R11: force idle
    ten = 1'b0;
    release_bus();
    sda = 1'b0; tick(2);
    chk("R11 busy before force", 32'(st), ST_BUSY);
    frc = 1'b1; tick(); frc = 1'b0;
    chk("R11 idle next cycle", 32'(st), ST_IDLE);
    scl = 1'b0; tick(); sda = 1'b1; tick(); scl = 1'b1; tick();
    sda = 1'b0; tick();
    chk("R11 frame closed by force", {30'd0, s_d, r_d}, 2);
    tick();
    chk("R11 busy after new start", 32'(st), ST_BUSY);

    // R12: force beats start in the same cycle
    release_bus();
    sda = 1'b0; tick();
    chk("R12 start pulse present", 32'(s_d), 1);
    frc = 1'b1; tick(); frc = 1'b0;
    chk("R12 force beats start", 32'(st), ST_IDLE);
    tick(3);
    chk("R12 idle held after force", 32'(st), ST_IDLE);

    // R12: start beats expiry in the same cycle
    ten = 1'b1; lim = LW'(6);
    scl = 1'b0; tick(); sda = 1'b1; tick(); scl = 1'b1; tick();
    sda = 1'b0; tick(2);
    chk("R12 busy before coincidence", 32'(st), ST_BUSY);
    scl = 1'b0; tick(); sda = 1'b1; tick(); scl = 1'b1;
    tick(7);
    chk("R12 still busy before expiry", 32'(st), ST_BUSY);
    sda = 1'b0; tick();
    chk("R12 coincident start pulse", 32'(s_d), 1);
    tick();
    chk("R12 start beats expiry", 32'(st), ST_BUSY);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule